// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is a full-duplex serial port in which transmit and receive always move on one shared shift clock. Software talks to it through four byte-wide registers. A single data address is shared by both directions: a write fills the transmit holding register and a read returns the last received byte. Eight bits make one transfer, and they are sent least-significant bit first.

The shift clock has two possible sources. The internal generator takes the system clock, can divide it by 4 first, and then divides by (n+1), where n is an 8-bit reload value. This gives a shift clock from 1/2 down to 1/2048 of the system clock. In external mode the edges come from an input pin instead, and that pin is synchronised to the system clock. In internal mode, a write to the data address starts the transfer. If another byte is written while a shift is still running, it follows on with no pause in the clock.

Four flags report progress: transmit holding register empty, shifter idle, receive byte present, and overrun. There is a transmit interrupt whose trigger can be set to either the holding-register-empty event or the shifter-finished event. There is also a receive interrupt.

Top module: `sio_sync_port`

Register map (2-bit `reg_addr`):
- 0: data. A write loads the transmit holding register; a read returns the receive byte.
- 1: status, read only. Bit 0 = TX_EMPTY, bit 1 = SHIFT_IDLE, bit 2 = RX_FULL, bit 3 = OVERRUN.
- 2: control. Bit 0 = external clock, bit 1 = divide by 4, bit 2 = transmit interrupt on shifter finished (0 = on holding register empty).
- 3: reload value n.

## Requirements
- R1: After reset the status register reads 8'h03 (TX_EMPTY=1, SHIFT_IDLE=1, RX_FULL=0, OVERRUN=0), `sclk_out` is high, and both interrupt outputs are low.
- R2: With the internal clock selected, writing the data address starts a transfer. Once the byte has moved into the shifter, status reads TX_EMPTY=1 and SHIFT_IDLE=0 (8'h01) until the last bit is done.
- R3: Each phase of the internal shift clock lasts (n+1)·P system cycles, where P=4 when control bit 1 is set and P=1 otherwise. `sclk_out` stays high while the port is idle.
- R4: Data is sent and received LSB first. `sdo` changes only on falling shift-clock edges, `sdi` is sampled on rising edges, and the byte received is read back at address 0.
- R5: A byte written while SHIFT_IDLE=0 follows the current byte with no gap. For two bytes, the time from the first falling edge to the last rising edge is exactly 31 phases.
- R6: `tx_irq` is a one-cycle pulse. With control bit 2 clear it fires when TX_EMPTY rises. With control bit 2 set it fires when SHIFT_IDLE rises.
- R7: `rx_irq` is a one-cycle pulse issued when RX_FULL goes from 0 to 1. Reading address 0 clears RX_FULL.
- R8: OVERRUN is set when a byte completes while RX_FULL is 1, and the new byte overwrites the old one. OVERRUN is cleared only by a read of address 0 that follows a read of address 1.
- R9: With control bit 0 set, shifting follows the edges of `sclk_in` (falling edge = output, rising edge = sample), and `sclk_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock, idle high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions check the following on every cycle:
- the shift clock is high whenever the shifter is idle;
- `sdo` is stable on every rising edge;
- a pending byte is taken into an idle shifter within one cycle;
- the interrupt pulses are one cycle wide and line up with the rise of their flags;
- OVERRUN can only appear while a byte is already held;
- the clock output is parked in external mode.

Only the bench scenarios can show the rest. That covers the bit order and the exchanged values, the exact clock-phase length for each divider setting, the absence of a gap between chained bytes, and the read-order rule for clearing OVERRUN.

// File: rtl/sio_pkg.sv
// Package: register addresses, control and status bit positions shared by
// the serial port RTL. Assumes a 2-bit register address space.
package sio_pkg;
    localparam logic [1:0] ADDR_DATA   = 2'd0;
    localparam logic [1:0] ADDR_STAT   = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_RELOAD = 2'd3;

    localparam int CTRL_EXT     = 0;
    localparam int CTRL_PRE4    = 1;
    localparam int CTRL_TI_LATE = 2;
    localparam int CTRL_BITS    = 3;

    typedef struct packed {
        logic overrun;
        logic rx_full;
        logic shift_idle;
        logic tx_empty;
    } sio_flags_t;
endpackage

// File: rtl/sio_baud_gen.sv
// Module: internal shift-clock generator. An optional prescaler divides the
// system clock by PRESCALE, then a reloadable down-counter divides by (n+1).
// Every terminal count toggles the clock level, so one phase lasts
// (n+1)*P cycles. Assumes PRESCALE >= 2. While not active the level is
// parked high and both counters restart, so every transfer begins with a
// full first phase.
module sio_baud_gen #(
    parameter int RELOAD_W = 8,
    parameter int PRESCALE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                pre_en,
    input  logic [RELOAD_W-1:0] reload,
    output logic                fall_tick,
    output logic                rise_tick,
    output logic                sclk_lvl
);
    localparam int PRE_W = $clog2(PRESCALE);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0]    pre_cnt;
    logic [RELOAD_W-1:0] div_cnt;
    logic                lvl;
    logic                pre_tick;
    logic                tick;

    // Purpose: mark the prescaler output and the divider terminal count.
    always_comb begin
        pre_tick = !pre_en || (pre_cnt == PRE_LAST);
        tick     = active && pre_tick && (div_cnt == '0);
    end

    // Purpose: run both counters and toggle the clock level on each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pre_cnt <= '0;
            div_cnt <= reload;
            lvl     <= 1'b1;
        end else begin
            if (!pre_en || pre_tick) pre_cnt <= '0;
            else                     pre_cnt <= pre_cnt + 1'b1;
            if (pre_tick) begin
                if (div_cnt == '0) div_cnt <= reload;
                else               div_cnt <= div_cnt - 1'b1;
            end
            if (tick) lvl <= !lvl;
        end
    end

    assign fall_tick = tick && lvl;
    assign rise_tick = tick && !lvl;
    assign sclk_lvl  = lvl;
endmodule

// File: rtl/sio_edge_sync.sv
// Module: brings the external shift clock into the system clock domain
// through a chain of STAGES flops and reports each rising and falling edge
// as a one-cycle event. Assumes the external clock phases are longer than
// STAGES+1 system cycles. The line is taken to idle high.
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_evt,
    output logic fall_evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        // Purpose: one synchroniser stage.
        always_ff @(posedge clk) begin
            if (!rst_n)       chain[gi] <= 1'b1;
            else if (gi == 0) chain[gi] <= pin;
            else              chain[gi] <= chain[(gi == 0) ? 0 : gi - 1];
        end
    end

    // Purpose: keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign rise_evt = chain[STAGES-1] && !prev;
    assign fall_evt = !chain[STAGES-1] && prev;
endmodule

// File: rtl/sio_shifter.sv
// Module: the shared transmit/receive shift engine. It loads a pending
// holding byte when idle, drives the output bit on each falling event and
// samples the input on each rising event, LSB first. When the last bit is
// sampled it either reloads straight away (a byte is pending) or goes idle.
// Assumes rise and fall events never coincide.
module sio_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              fall_evt,
    input  logic              rise_evt,
    input  logic              sdi,
    output logic              sdo,
    output logic              busy,
    output logic              take,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              last;

    // Purpose: decode completion and holding-register hand-over.
    always_comb begin
        last    = (bit_cnt == LAST_BIT);
        done    = busy && rise_evt && last;
        take    = pending && (!busy || done);
        rx_word = {sdi, rx_sh[DATA_W-1:1]};
    end

    // Purpose: shift state; load, output on fall, sample on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b1;
        end else if (!busy) begin
            if (pending) begin
                busy    <= 1'b1;
                tx_sh   <= tx_word;
                bit_cnt <= '0;
            end
        end else if (fall_evt) begin
            sdo   <= tx_sh[0];
            tx_sh <= tx_sh >> 1;
        end else if (rise_evt) begin
            rx_sh   <= rx_word;
            bit_cnt <= bit_cnt + 1'b1;
            if (last) begin
                if (pending) tx_sh <= tx_word;
                else         busy  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_sync_port.sv
// Module: top of the clock-synchronous serial port. It holds the register
// file, the status flags and the interrupt pulses, and it chooses between
// the internal generator and the synchronised external clock. Assumes
// RELOAD_W <= DATA_W and that sdi is stable around rising clock events.
module sio_sync_port
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RELOAD_W    = 8,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdi,
    output logic              sdo,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [RELOAD_W-1:0]  reload_q;
    logic [DATA_W-1:0]    txbuf_q;
    logic [DATA_W-1:0]    rxbuf_q;
    logic                 flag_tbe;
    logic                 flag_rbf;
    logic                 flag_oe;
    logic                 stat_seen;
    logic                 wr_data, rd_data, rd_stat;
    logic                 sel_ext, sel_pre4, sel_ti_late;
    logic                 int_fall, int_rise, int_lvl;
    logic                 ext_fall, ext_rise;
    logic                 fall_evt, rise_evt;
    logic                 shift_busy, shift_idle;
    logic                 take, done;
    logic [DATA_W-1:0]    rx_word;
    sio_flags_t           flags;

    // Purpose: decode accesses and control fields.
    always_comb begin
        wr_data     = reg_wr && (reg_addr == ADDR_DATA);
        rd_data     = reg_rd && (reg_addr == ADDR_DATA);
        rd_stat     = reg_rd && (reg_addr == ADDR_STAT);
        sel_ext     = ctrl_q[CTRL_EXT];
        sel_pre4    = ctrl_q[CTRL_PRE4];
        sel_ti_late = ctrl_q[CTRL_TI_LATE];
        shift_idle  = !shift_busy;
    end

    sio_baud_gen #(
        .RELOAD_W (RELOAD_W),
        .PRESCALE (PRESCALE)
    ) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (shift_busy && !sel_ext),
        .pre_en    (sel_pre4),
        .reload    (reload_q),
        .fall_tick (int_fall),
        .rise_tick (int_rise),
        .sclk_lvl  (int_lvl)
    );

    sio_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) ext_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (sclk_in),
        .rise_evt (ext_rise),
        .fall_evt (ext_fall)
    );

    // Purpose: pick the active source of shift events.
    always_comb begin
        fall_evt = sel_ext ? ext_fall : int_fall;
        rise_evt = sel_ext ? ext_rise : int_rise;
    end

    sio_shifter #(
        .DATA_W (DATA_W)
    ) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (!flag_tbe),
        .tx_word  (txbuf_q),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .sdi      (sdi),
        .sdo      (sdo),
        .busy     (shift_busy),
        .take     (take),
        .done     (done),
        .rx_word  (rx_word)
    );

    // Purpose: configuration registers and the transmit holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            txbuf_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_DATA:   txbuf_q  <= reg_wdata;
                ADDR_CTRL:   ctrl_q   <= reg_wdata[CTRL_BITS-1:0];
                ADDR_RELOAD: reload_q <= reg_wdata[RELOAD_W-1:0];
                default:     ;
            endcase
        end
    end

    // Purpose: transmit-empty flag; a write fills the holding register, a take empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_tbe <= 1'b1;
        else if (wr_data) flag_tbe <= 1'b0;
        else if (take)    flag_tbe <= 1'b1;
    end

    // Purpose: receive byte, receive-full flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf_q  <= '0;
            flag_rbf <= 1'b0;
            flag_oe  <= 1'b0;
        end else begin
            if (done)         rxbuf_q  <= rx_word;
            if (done)         flag_rbf <= 1'b1;
            else if (rd_data) flag_rbf <= 1'b0;
            if (done && flag_rbf && !rd_data) flag_oe <= 1'b1;
            else if (rd_data && stat_seen)    flag_oe <= 1'b0;
        end
    end

    // Purpose: remember a status read so that a following data read clears overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_seen <= 1'b0;
        else if (rd_stat) stat_seen <= 1'b1;
        else if (rd_data) stat_seen <= 1'b0;
    end

    // Purpose: one-cycle interrupt pulses, aligned with the rise of the flags they follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
        end else begin
            tx_irq <= sel_ti_late ? (done && flag_tbe) : (take && !wr_data);
            rx_irq <= done && (!flag_rbf || rd_data);
        end
    end

    // Purpose: read data multiplexer.
    always_comb begin
        flags.overrun    = flag_oe;
        flags.rx_full    = flag_rbf;
        flags.shift_idle = shift_idle;
        flags.tx_empty   = flag_tbe;
        case (reg_addr)
            ADDR_DATA:   reg_rdata = rxbuf_q;
            ADDR_STAT:   reg_rdata = DATA_W'(flags);
            ADDR_CTRL:   reg_rdata = DATA_W'(ctrl_q);
            default:     reg_rdata = DATA_W'(reload_q);
        endcase
    end

    assign sclk_out = sel_ext ? 1'b1 : int_lvl;
endmodule

// File: rtl/sio_sync_port_chk.sv
// Module: assertion checker for the serial port, bound into the top module.
module sio_sync_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_out,
    input logic sdo,
    input logic tx_irq,
    input logic rx_irq,
    input logic flag_tbe,
    input logic flag_rbf,
    input logic flag_oe,
    input logic shift_idle,
    input logic sel_ti_late,
    input logic sel_ext
);
    assert_idle_clk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_idle |-> sclk_out);

    assert_sdo_steady_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_out) |-> $stable(sdo));

    assert_pending_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_idle && !flag_tbe) |=> !shift_idle);

    assert_txirq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    assert_txirq_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shift_idle) && $past(sel_ti_late)) |-> tx_irq);

    assert_rxirq_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rbf) |-> rx_irq);

    assert_rxirq_has_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> flag_rbf);

    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_oe) |-> $past(flag_rbf));

    assert_ext_clk_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ext |-> sclk_out);
endmodule

bind sio_sync_port sio_sync_port_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_out    (sclk_out),
    .sdo         (sdo),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq),
    .flag_tbe    (flag_tbe),
    .flag_rbf    (flag_rbf),
    .flag_oe     (flag_oe),
    .shift_idle  (shift_idle),
    .sel_ti_late (sel_ti_late),
    .sel_ext     (sel_ext)
);

// File: tb/sio_sync_port_tb.sv
`timescale 1ns/1ps
module sio_sync_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sclk_in = 1'b1;
    logic       sclk_out;
    logic       sdi;
    logic       sdo;
    logic       tx_irq;
    logic       rx_irq;

    int n_checks = 0;
    int n_errs = 0;

    always #4 clk = !clk;

    sio_sync_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk_in   (sclk_in),
        .sclk_out  (sclk_out),
        .sdi       (sdi),
        .sdo       (sdo),
        .tx_irq    (tx_irq),
        .rx_irq    (rx_irq)
    );

    // Bench-side peer: the line clock, data capture and the reply pattern.
    logic        ext_sel = 1'b0;
    logic        line_clk;
    logic [15:0] cap = '0;
    logic [15:0] slave_word = '0;
    logic [31:0] fall_cnt = 0;
    logic [31:0] fall_base = 0;
    logic [31:0] k_idx;
    int          int_falls = 0;
    int          mark = 0;
    time         t_fall = 0, t_rise = 0, t_first = 0;
    int          hp_lo = 0;
    int          txirq_cnt = 0, rxirq_cnt = 0;

    assign line_clk = ext_sel ? sclk_in : sclk_out;
    assign k_idx    = fall_cnt - fall_base - 1;
    assign sdi      = slave_word[k_idx[3:0]];

    always @(posedge line_clk) cap <= {sdo, cap[15:1]};
    always @(negedge line_clk) fall_cnt <= fall_cnt + 1;
    always @(negedge sclk_out) begin
        if (int_falls == mark) t_first = $time;
        t_fall = $time;
        int_falls = int_falls + 1;
    end
    always @(posedge sclk_out) begin
        t_rise = $time;
        hp_lo = int'((t_rise - t_fall) / 8);
    end
    always @(negedge clk) begin
        if (tx_irq) txirq_cnt = txirq_cnt + 1;
        if (rx_irq) rxirq_cnt = rxirq_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Vectors: {ctrl, reload, tx byte, peer byte, expected phase length}
    localparam logic [39:0] VEC [5] = '{
        {8'h00, 8'h00, 8'hA5, 8'h3C, 8'd1},
        {8'h02, 8'h00, 8'h5A, 8'hC3, 8'd4},
        {8'h00, 8'h03, 8'h81, 8'h7E, 8'd4},
        {8'h06, 8'h02, 8'h0F, 8'hF0, 8'd12},
        {8'h04, 8'h01, 8'h96, 8'h69, 8'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int tx0, rx0, f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 sclk_out idle", {31'd0, sclk_out}, 1);
        check("R1 tx_irq low", {31'd0, tx_irq}, 0);
        check("R1 rx_irq low", {31'd0, rx_irq}, 0);
        reg_read(2'd1, rd);
        check("R1 status", {24'd0, rd}, 32'h03);

        // Table walk: R2 R3 R4 R6 R7
        for (int v = 0; v < 5; v++) begin
            logic [7:0] c, n, tx, pv, h;
            {c, n, tx, pv, h} = VEC[v];
            reg_write(2'd2, c);
            reg_write(2'd3, n);
            slave_word = {8'h00, pv};
            fall_base = fall_cnt;
            mark = int_falls;
            tx0 = txirq_cnt; rx0 = rxirq_cnt;
            reg_write(2'd0, tx);
            reg_read(2'd1, rd);
            check("R2 busy status", {24'd0, rd}, 32'h01);
            repeat (20 * int'(h) + 20) @(negedge clk);
            check("R4 sent LSB first", {24'd0, cap[15:8]}, {24'd0, tx});
            check("R3 low phase", hp_lo, {24'd0, h});
            check("R3 transfer span", int'((t_rise - t_first) / 8), 15 * int'(h));
            check("R3 idle clock high", {31'd0, sclk_out}, 1);
            check("R6 one tx pulse", txirq_cnt - tx0, 1);
            check("R7 one rx pulse", rxirq_cnt - rx0, 1);
            reg_read(2'd1, rd);
            check("R7 rx full", {24'd0, rd}, 32'h07);
            reg_read(2'd0, rd);
            check("R4 received byte", {24'd0, rd}, {24'd0, pv});
            reg_read(2'd1, rd);
            check("R7 read clears full", {24'd0, rd}, 32'h03);
        end

        // R5 / R8: chained bytes with no gap, second byte overruns
        reg_write(2'd2, 8'h00);
        reg_write(2'd3, 8'h01);
        reg_read(2'd0, rd);
        slave_word = {8'h5B, 8'hE1};
        fall_base = fall_cnt;
        mark = int_falls;
        tx0 = txirq_cnt; rx0 = rxirq_cnt;
        reg_write(2'd0, 8'h3C);
        repeat (3) @(negedge clk);
        reg_write(2'd0, 8'hC5);
        repeat (120) @(negedge clk);
        check("R5 both bytes out", {16'd0, cap}, 32'hC53C);
        check("R5 no gap span", int'((t_rise - t_first) / 8), 62);
        check("R6 two empty pulses", txirq_cnt - tx0, 2);
        check("R7 no pulse on overrun", rxirq_cnt - rx0, 1);
        reg_read(2'd0, rd);
        check("R8 newest byte kept", {24'd0, rd}, 32'h5B);
        reg_read(2'd1, rd);
        check("R8 overrun survives lone data read", {24'd0, rd}, 32'h0B);
        reg_read(2'd0, rd);
        reg_read(2'd1, rd);
        check("R8 overrun cleared", {24'd0, rd}, 32'h03);

        // R9: external clock
        reg_write(2'd2, 8'h01);
        ext_sel = 1'b1;
        slave_word = {8'h00, 8'hB4};
        fall_base = fall_cnt;
        f0 = int_falls;
        reg_write(2'd0, 8'hD2);
        repeat (10) @(negedge clk);
        reg_read(2'd1, rd);
        check("R9 waits for external clock", {24'd0, rd}, 32'h01);
        for (int b = 0; b < 8; b++) begin
            sclk_in = 1'b0;
            repeat (8) @(negedge clk);
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R9 sent byte", {24'd0, cap[15:8]}, 32'hD2);
        reg_read(2'd0, rd);
        check("R9 received byte", {24'd0, rd}, 32'hB4);
        reg_read(2'd1, rd);
        check("R9 idle after transfer", {24'd0, rd}, 32'h03);
        check("R9 sclk_out never toggled", int_falls - f0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule